// File: doc/BRIEF.md
# Sector Load and Program Sequencer

This block is the write side of a behavioural nonvolatile memory that is reprogrammed one whole sector at a time. A host issues byte loads as pulses on an active-low write strobe. Each pulse carries an address and a data byte. The low address bits pick a byte slot inside a sector-sized holding buffer, and the upper bits name the sector. Loads may arrive in any order. The first accepted byte fixes the target sector for the whole load.

No command ends the load phase. It ends when the inter-byte window timer runs out before another strobe arrives. The block then goes busy for a fixed program cycle. In the first part of that cycle it erases the whole target sector to all ones. In the second part it copies every buffered byte into the memory array, so any slot that was not loaded keeps the erased value. While busy, the block ignores strobes, so the host address and data lines are free for other work.

A one-port read path with registered output lets the surrounding model, and the bench, look at the array contents. The block also reports the address and data of the most recently accepted byte, plus a flag that is set when a byte aimed at a different sector was rejected.

Top module: `sector_prog_seq`

## Requirements
- R1: A synchronous active-high `rst` clears `busy`, `sect_err`, `last_addr` and `last_data` to zero. It also abandons any load in progress, so no program cycle follows it.
- R2: `wr_n` is sampled on every rising clock edge.
  - The byte's address is taken from `addr` on the first edge at which `wr_n` is low after being high.
  - Its data is taken from `din` on the first edge at which `wr_n` is high again.
  - From the next clock on, `last_addr` and `last_data` show that address and data.
  - Changes on `addr` while the strobe is low, and changes on `din` before the high sample, have no effect.
- R3: Bytes may be loaded in any order. After the commit, the byte loaded at offset k of sector s reads back at array address s*2^OFF_W + k. When an offset is loaded twice in one load, the later data is kept.
- R4: Count the edge that samples a byte's rising strobe as edge 0. The load continues if the next falling sample comes at or before edge LOAD_WIN. Otherwise `busy` reads 1 from the clock after edge LOAD_WIN. The window counter is held while no load is in progress, so idle time before the first byte does not shorten the window.
- R5: During a load, a byte whose upper address bits differ from the first byte's sector has no effect:
  - its data is not stored;
  - `last_addr` and `last_data` keep their values;
  - `sect_err` rises on the clock after its falling sample.

  `sect_err` returns to 0 when the first byte of a later load is sampled.
- R6: `busy` stays high for exactly CYCLE_LEN clocks, then drops.
- R7: Strobes during the busy period change neither `last_addr` nor `last_data`, and they do not start a load once `busy` drops.
- R8: After a commit, every offset of the target sector that was not loaded reads all ones (0xFF for DATA_W = 8). This includes offsets that held data from an earlier commit. All other sectors keep their contents.
- R9: `rd_data` shows the array word at `rd_addr`, as sampled on the previous clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_n | input | 1 | Byte load strobe, active low |
| addr | input | SECT_W+OFF_W | Load address: sector in the upper bits, byte offset in the low OFF_W bits |
| din | input | DATA_W | Load data |
| rd_addr | input | SECT_W+OFF_W | Array read address |
| rd_data | output | DATA_W | Array read data, one clock latency |
| busy | output | 1 | Program cycle in progress |
| last_addr | output | SECT_W+OFF_W | Address of the last accepted byte |
| last_data | output | DATA_W | Data of the last accepted byte |
| sect_err | output | 1 | A byte for another sector was rejected during the current or last load |

## Verification
The properties assume that `wr_n` is synchronous to `clk` and is held high through reset. They also assume that every strobe stays low and then high for at least one sampled clock each, so every falling sample has a matching rising sample. The bench drives all inputs on the falling clock edge. It holds each strobe low for two samples and moves `addr` and `din` away from the captured values around the capture edges. It spaces loads by counted gaps of up to the longest gap the window still accepts. Strobes issued inside the busy period are complete pulses, so no half-pulse is left pending when the cycle ends.

// File: rtl/spq_pkg.sv
package spq_pkg;
  localparam int BYTE_W = 8;

  // sequencer phases
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOAD = 2'd1,
    PH_PROG = 2'd2
  } phase_e;
endpackage

// File: rtl/spq_window_timer.sv
// Inter-byte load window: restarts on each accepted byte, pauses while a
// strobe is low, and flags expiry when the window has elapsed.
module spq_window_timer #(
  parameter int LOAD_WIN = 7500
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             run,
  input  logic                             restart,
  input  logic                             hold,
  output logic [$clog2(LOAD_WIN+1)-1:0]    cnt,
  output logic                             expire
);
  localparam int CW = $clog2(LOAD_WIN + 1);
  localparam logic [CW-1:0] LIM = CW'(LOAD_WIN - 1);

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt <= '0;
    end else if (restart) begin
      cnt <= '0;
    end else if (!hold && cnt != LIM) begin
      cnt <= cnt + 1'b1;
    end
  end

  assign expire = run && !hold && (cnt == LIM);
endmodule

// File: rtl/spq_prog_timer.sv
// Fixed-length program cycle: erase walk over the sector, then a copy walk
// that reads the buffer and writes the array one clock later.
module spq_prog_timer #(
  parameter int OFF_W     = 8,
  parameter int CYCLE_LEN = 500000
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              run,
  output logic [$clog2(CYCLE_LEN+1)-1:0]    cnt,
  output logic                              done,
  output logic                              erase_we,
  output logic [OFF_W-1:0]                  erase_idx,
  output logic                              buf_re,
  output logic [OFF_W-1:0]                  buf_ridx,
  output logic                              prog_we,
  output logic [OFF_W-1:0]                  prog_idx
);
  localparam int CW = $clog2(CYCLE_LEN + 1);
  localparam int NB = 2 ** OFF_W;
  localparam logic [CW-1:0] LIM    = CW'(CYCLE_LEN - 1);
  localparam logic [CW-1:0] ER_END = CW'(NB);
  localparam logic [CW-1:0] PG_END = CW'(2 * NB);

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  assign done      = run && (cnt == LIM);
  assign erase_we  = run && (cnt < ER_END);
  assign erase_idx = cnt[OFF_W-1:0];
  assign buf_re    = run && (cnt >= ER_END) && (cnt < PG_END);
  assign buf_ridx  = cnt[OFF_W-1:0];

  // align the array write with the registered buffer read
  always_ff @(posedge clk) begin
    if (rst) begin
      prog_we  <= 1'b0;
      prog_idx <= '0;
    end else begin
      prog_we  <= buf_re;
      prog_idx <= buf_ridx;
    end
  end
endmodule

// File: rtl/spq_sector_buf.sv
// Sector holding buffer: RAM for data, flop vector for per-slot loaded flags.
module spq_sector_buf #(
  parameter int OFF_W  = 8,
  parameter int DATA_W = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               clr,
  input  logic               we,
  input  logic [OFF_W-1:0]   widx,
  input  logic [DATA_W-1:0]  wdata,
  input  logic               re,
  input  logic [OFF_W-1:0]   ridx,
  output logic [DATA_W-1:0]  rdata,
  output logic               rvalid
);
  localparam int NB = 2 ** OFF_W;

  logic [DATA_W-1:0] mem [NB];
  logic [NB-1:0]     loaded;

  always_ff @(posedge clk) begin
    if (we) mem[widx] <= wdata;
    if (re) rdata <= mem[ridx];
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      loaded <= '0;
    end else if (we) begin
      loaded[widx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rvalid <= 1'b0;
    end else if (re) begin
      rvalid <= loaded[ridx];
    end
  end
endmodule

// File: rtl/spq_mem_array.sv
// Behavioural storage array, one write port and one registered read port.
module spq_mem_array #(
  parameter int AW = 11,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 2 ** AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/sector_prog_seq.sv
module sector_prog_seq
  import spq_pkg::*;
#(
  parameter int SECT_W    = 3,
  parameter int OFF_W     = 8,
  parameter int DATA_W    = BYTE_W,
  parameter int LOAD_WIN  = 7500,
  parameter int CYCLE_LEN = 500000
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      wr_n,
  input  logic [SECT_W+OFF_W-1:0]   addr,
  input  logic [DATA_W-1:0]         din,
  input  logic [SECT_W+OFF_W-1:0]   rd_addr,
  output logic [DATA_W-1:0]         rd_data,
  output logic                      busy,
  output logic [SECT_W+OFF_W-1:0]   last_addr,
  output logic [DATA_W-1:0]         last_data,
  output logic                      sect_err
);
  localparam int ADDR_W = SECT_W + OFF_W;
  localparam int WCW    = $clog2(LOAD_WIN + 1);
  localparam int CCW    = $clog2(CYCLE_LEN + 1);
  localparam logic [DATA_W-1:0] ERASED = '1;

  phase_e             phase;
  logic               wr_q, pend;
  logic [SECT_W-1:0]  sect_q;
  logic [OFF_W-1:0]   off_q;

  logic fall, rise, sect_hit, fall_ok, fall_bad, rise_acc;
  logic expire, done;
  logic [WCW-1:0] win_cnt;
  logic [CCW-1:0] cyc_cnt;

  logic              erase_we, buf_re, prog_we, buf_rvalid;
  logic [OFF_W-1:0]  erase_idx, buf_ridx, prog_idx;
  logic [DATA_W-1:0] buf_rdata;
  logic              arr_we;
  logic [ADDR_W-1:0] arr_waddr;
  logic [DATA_W-1:0] arr_wdata;

  // strobe edges from the sampled strobe level
  assign fall     = wr_q && !wr_n;
  assign rise     = !wr_q && wr_n;
  assign sect_hit = (addr[ADDR_W-1:OFF_W] == sect_q);
  assign fall_ok  = fall && ((phase == PH_IDLE) || ((phase == PH_LOAD) && sect_hit));
  assign fall_bad = fall && (phase == PH_LOAD) && !sect_hit;
  assign rise_acc = rise && pend;
  assign busy     = (phase == PH_PROG);

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_q      <= 1'b1;
      pend      <= 1'b0;
      phase     <= PH_IDLE;
      sect_q    <= '0;
      off_q     <= '0;
      last_addr <= '0;
      last_data <= '0;
      sect_err  <= 1'b0;
    end else begin
      wr_q <= wr_n;

      if (fall_ok) begin
        pend  <= 1'b1;
        off_q <= addr[OFF_W-1:0];
      end else if (rise) begin
        pend <= 1'b0;
      end

      if (fall_ok && phase == PH_IDLE) begin
        sect_q   <= addr[ADDR_W-1:OFF_W];
        sect_err <= 1'b0;
      end else if (fall_bad) begin
        sect_err <= 1'b1;
      end

      if (rise_acc) begin
        last_addr <= {sect_q, off_q};
        last_data <= din;
      end

      case (phase)
        PH_IDLE: if (fall_ok) phase <= PH_LOAD;
        PH_LOAD: if (expire)  phase <= PH_PROG;
        PH_PROG: if (done)    phase <= PH_IDLE;
        default:              phase <= PH_IDLE;
      endcase
    end
  end

  spq_window_timer #(.LOAD_WIN(LOAD_WIN)) u_win (
    .clk     (clk),
    .rst     (rst),
    .run     (phase == PH_LOAD),
    .restart (rise_acc),
    .hold    (pend || fall_ok),
    .cnt     (win_cnt),
    .expire  (expire)
  );

  spq_prog_timer #(.OFF_W(OFF_W), .CYCLE_LEN(CYCLE_LEN)) u_cyc (
    .clk       (clk),
    .rst       (rst),
    .run       (busy),
    .cnt       (cyc_cnt),
    .done      (done),
    .erase_we  (erase_we),
    .erase_idx (erase_idx),
    .buf_re    (buf_re),
    .buf_ridx  (buf_ridx),
    .prog_we   (prog_we),
    .prog_idx  (prog_idx)
  );

  spq_sector_buf #(.OFF_W(OFF_W), .DATA_W(DATA_W)) u_buf (
    .clk    (clk),
    .rst    (rst),
    .clr    (done),
    .we     (rise_acc),
    .widx   (off_q),
    .wdata  (din),
    .re     (buf_re),
    .ridx   (buf_ridx),
    .rdata  (buf_rdata),
    .rvalid (buf_rvalid)
  );

  // erase writes ones across the sector; copy writes only loaded slots
  assign arr_we    = erase_we || (prog_we && buf_rvalid);
  assign arr_waddr = {sect_q, (erase_we ? erase_idx : prog_idx)};
  assign arr_wdata = erase_we ? ERASED : buf_rdata;

  spq_mem_array #(.AW(ADDR_W), .DW(DATA_W)) u_arr (
    .clk   (clk),
    .we    (arr_we),
    .waddr (arr_waddr),
    .wdata (arr_wdata),
    .raddr (rd_addr),
    .rdata (rd_data)
  );
endmodule

// File: rtl/spq_chk.sv
module spq_chk #(
  parameter int LOAD_WIN  = 7500,
  parameter int CYCLE_LEN = 500000,
  parameter int AW        = 11,
  parameter int DW        = 8
) (
  input logic                             clk,
  input logic                             rst,
  input logic                             wr_n,
  input logic                             busy,
  input logic [AW-1:0]                    last_addr,
  input logic [DW-1:0]                    last_data,
  input logic                             sect_err,
  input logic [$clog2(LOAD_WIN+1)-1:0]    win_cnt,
  input logic [$clog2(CYCLE_LEN+1)-1:0]   cyc_cnt
);
  localparam int WCW = $clog2(LOAD_WIN + 1);
  localparam int CCW = $clog2(CYCLE_LEN + 1);

  // R4
  win_expiry_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> ($past(win_cnt) == WCW'(LOAD_WIN - 1)));

  // R6
  cycle_len_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> ($past(cyc_cnt) == CCW'(CYCLE_LEN - 1)));

  // R7
  busy_freeze_chk: assert property (@(posedge clk) disable iff (rst)
    busy |=> ($stable(last_addr) && $stable(last_data)));

  // R2
  capture_on_rise_chk: assert property (@(posedge clk) disable iff (rst)
    (!$stable(last_data) || !$stable(last_addr)) |-> ($past(wr_n) && !$past(wr_n, 2)));

  // R5
  err_on_fall_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(sect_err) |-> (!$past(wr_n) && !$past(busy)));
endmodule

bind sector_prog_seq spq_chk #(
  .LOAD_WIN  (LOAD_WIN),
  .CYCLE_LEN (CYCLE_LEN),
  .AW        (SECT_W + OFF_W),
  .DW        (DATA_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .wr_n      (wr_n),
  .busy      (busy),
  .last_addr (last_addr),
  .last_data (last_data),
  .sect_err  (sect_err),
  .win_cnt   (win_cnt),
  .cyc_cnt   (cyc_cnt)
);

// File: tb/sim_sector_prog_seq.sv
module sim_sector_prog_seq;
  localparam int SW = 2;
  localparam int OW = 8;
  localparam int DW = 8;
  localparam int LW = 16;
  localparam int CL = 600;
  localparam int AW = SW + OW;
  localparam int NB = 2 ** OW;
  localparam int NV = 8;
  // {offset, data, gap}; entry 2 uses the longest accepted gap (LW-2 here)
  localparam logic [23:0] VEC [NV] = '{
    24'h10A503, 24'hFF5A00, 24'h003C0E, 24'h80C301,
    24'h107702, 24'h7F0105, 24'h01FE00, 24'h400000
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [AW-1:0] rd_addr = '0;
  logic [DW-1:0] din = '0;
  logic [DW-1:0] rd_data, last_data;
  logic [AW-1:0] last_addr;
  logic busy, sect_err;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  logic [DW-1:0] exp_mem [NB];
  bit            loaded  [NB];

  always #10 clk = ~clk;

  sector_prog_seq #(.SECT_W(SW), .OFF_W(OW), .DATA_W(DW),
                    .LOAD_WIN(LW), .CYCLE_LEN(CL)) u0 (
    .clk(clk), .rst(rst), .wr_n(wr_n), .addr(addr), .din(din),
    .rd_addr(rd_addr), .rd_data(rd_data), .busy(busy),
    .last_addr(last_addr), .last_data(last_data), .sect_err(sect_err)
  );

  function automatic logic [AW-1:0] mk(int s, int o);
    return AW'(s * NB + o);
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic strobe(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk); wr_n = 1'b0; addr = a;  din = ~d;
    @(negedge clk); addr = ~a; din = d;
    @(negedge clk); wr_n = 1'b1;
    @(negedge clk); din = ~d; addr = '0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] d);
    @(negedge clk); rd_addr = a;
    @(negedge clk); d = rd_data;
  endtask

  task automatic wait_done();
    int n = 0;
    while (!busy && n < 4 * CL) begin @(negedge clk); n++; end
    while (busy && n < 4 * CL) begin @(negedge clk); n++; end
    chk("R6 program cycle completes", 32'(busy), 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] v;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 busy", 32'(busy), 32'd0);
    chk("R1 sect_err", 32'(sect_err), 32'd0);
    chk("R1 last_addr", 32'(last_addr), 32'd0);
    chk("R1 last_data", 32'(last_data), 32'd0);

    for (int i = 0; i < NB; i++) begin exp_mem[i] = 8'hFF; loaded[i] = 0; end

    // table-driven load of sector 2 in scrambled order
    for (int i = 0; i < NV; i++) begin
      logic [7:0] o, d, g;
      {o, d, g} = VEC[i];
      strobe(mk(2, int'(o)), d);
      exp_mem[o] = d;
      loaded[o]  = 1;
      chk("R2 last_addr", 32'(last_addr), 32'(mk(2, int'(o))));
      chk("R2 last_data", 32'(last_data), 32'(d));
      chk("R4 still loading", 32'(busy), 32'd0);
      if (i < NV - 1) repeat (int'(g)) @(negedge clk);
    end
    repeat (LW - 1) @(negedge clk);
    chk("R4 window not yet expired", 32'(busy), 32'd0);
    @(negedge clk);
    chk("R4 window expired", 32'(busy), 32'd1);

    // strobe while busy is ignored
    strobe(mk(1, 8'h33), 8'h99);
    chk("R7 last_addr frozen", 32'(last_addr), 32'(mk(2, 8'h40)));
    chk("R7 last_data frozen", 32'(last_data), 32'h00);
    repeat (CL - 5) @(negedge clk);
    chk("R6 busy in last cycle", 32'(busy), 32'd1);
    @(negedge clk);
    chk("R6 busy dropped", 32'(busy), 32'd0);
    repeat (LW + 4) @(negedge clk);
    chk("R7 no load started", 32'(busy), 32'd0);

    for (int k = 0; k < NB; k++) begin
      rd(mk(2, k), v);
      if (loaded[k]) chk("R3 loaded byte", 32'(v), 32'(exp_mem[k]));
      else           chk("R8 unloaded byte", 32'(v), 32'(exp_mem[k]));
    end

    // sector mismatch after a long idle
    strobe(mk(1, 8'h05), 8'h11);
    chk("R4 idle does not shorten window", 32'(busy), 32'd0);
    chk("R5 no error yet", 32'(sect_err), 32'd0);
    strobe(mk(3, 8'h06), 8'h22);
    chk("R5 error raised", 32'(sect_err), 32'd1);
    chk("R5 last_addr kept", 32'(last_addr), 32'(mk(1, 8'h05)));
    chk("R5 last_data kept", 32'(last_data), 32'h11);
    wait_done();
    rd(mk(1, 8'h05), v);
    chk("R3 sector 1 byte", 32'(v), 32'h11);
    rd(mk(1, 8'h06), v);
    chk("R5 rejected byte not stored", 32'(v), 32'hFF);

    strobe(mk(3, 8'h00), 8'h33);
    chk("R5 error cleared by new load", 32'(sect_err), 32'd0);
    wait_done();
    rd(mk(3, 8'h00), v);
    chk("R9 read port", 32'(v), 32'h33);

    // reprogram sector 2 with a single byte: old contents erased
    strobe(mk(2, 8'h80), 8'h5E);
    wait_done();
    rd(mk(2, 8'h80), v);
    chk("R3 reprogrammed byte", 32'(v), 32'h5E);
    rd(mk(2, 8'h10), v);
    chk("R8 old byte erased", 32'(v), 32'hFF);
    rd(mk(1, 8'h05), v);
    chk("R8 other sector kept", 32'(v), 32'h11);
    rd(mk(3, 8'h00), v);
    chk("R8 other sector kept", 32'(v), 32'h33);

    // reset in the middle of a load
    strobe(mk(0, 8'h01), 8'hAA);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 last_addr after reset", 32'(last_addr), 32'd0);
    chk("R1 last_data after reset", 32'(last_data), 32'd0);
    repeat (LW + 4) @(negedge clk);
    chk("R1 load abandoned", 32'(busy), 32'd0);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule